// File: doc/BRIEF.md
# Three-Component Colour Matrix Multiplier

This block multiplies a stream of three-component pixel vectors by a 3x3 matrix of signed coefficients. It is meant for colour space conversion, such as luma/chroma to RGB. Every clock it can accept one vector of three signed 12-bit components. Each of the three 12-bit results is the dot product of that vector with one matrix row. The coefficients are 10-bit two's complement numbers with 8 fraction bits, so the range runs from -2.0 up to just under +2.0. Each result is rounded and clamped to the signed 12-bit range.

Coefficients are written one row per cycle, three values at a time, into a staging copy. Writing the last row moves the whole staged matrix into use in a single step. A full reload therefore takes three cycles and never stalls the data stream. No output is ever computed from a mix of old and new rows. All inputs are registered on the rising clock edge. A valid flag travels through the pipeline beside the data.

Top module: `color_matrix_mul`

## Requirements
- R1: While reset is asserted, and immediately after it, `out_valid` is 0 and all three outputs are 0.
- R2: After reset, both the staged matrix and the active matrix are the identity: diagonal 256, which is 1.0, and all other entries 0. Until a new matrix is committed, each output equals the matching input (`out_x`=`in_a`, `out_y`=`in_b`, `out_z`=`in_c`).
- R3: Output row r (0=`out_x`, 1=`out_y`, 2=`out_z`) is computed from the coefficient of column 0 times `in_a`, plus column 1 times `in_b`, plus column 2 times `in_c`. All arithmetic is exact two's complement.
- R4: The sum is rounded by adding 128 and then shifting arithmetically right by 8 bits. Halves therefore round toward plus infinity: 128/256 gives 1, 127/256 gives 0, -128/256 gives 0 and -129/256 gives -1.
- R5: A rounded result above 2047 gives 2047, and a rounded result below -2048 gives -2048.
- R6: A vector present at the ports before rising edge k appears on the outputs after edge k+4. `out_valid` carries that vector's `in_valid`. A new vector is accepted on every cycle, and gaps in the input stream are reproduced at the output.
- R7: With `coef_we`=1 and `coef_row` set to 0, 1 or 2, the values `coef_k0`, `coef_k1` and `coef_k2` are stored into columns 0, 1 and 2 of that row of the staged matrix. Writing row 0 or row 1 does not change the outputs.
- R8: Writing row 2 makes the whole staged matrix active at once, including the new row 2. Vectors presented in the same cycle as that write, or earlier, use the old matrix. Vectors presented one cycle later or after use the new matrix.
- R9: A write with `coef_row`=3 changes neither the staged matrix nor the active matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is valid |
| in_a | input | 12 | Input component 0, signed |
| in_b | input | 12 | Input component 1, signed |
| in_c | input | 12 | Input component 2, signed |
| coef_we | input | 1 | Coefficient row write enable |
| coef_row | input | 2 | Row to write (0..2; 3 is ignored) |
| coef_k0 | input | 10 | Column 0 coefficient, signed, 8 fraction bits |
| coef_k1 | input | 10 | Column 1 coefficient, signed |
| coef_k2 | input | 10 | Column 2 coefficient, signed |
| out_valid | output | 1 | Output vector is valid |
| out_x | output | 12 | Result of row 0, signed |
| out_y | output | 12 | Result of row 1, signed |
| out_z | output | 12 | Result of row 2, signed |

## Verification
A corrupted active coefficient shows up as a wrong result on one output. It appears exactly five edges after the first vector that reads that coefficient, and it stays wrong on every later vector until the next commit. A matrix committed one cycle early or late shows up on the vector presented in the same cycle as the row-2 write, or on the vector right after it. The bench therefore streams vectors without gaps across every reload. A stuck staged row stays hidden until the next row-2 commit, which is why the bench commits row 2 on its own after partial loads and after an ignored row-3 write.

// File: rtl/color_matrix_mul.sv
module color_matrix_mul #(
  parameter int DW   = 12,
  parameter int CW   = 10,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic signed [DW-1:0] in_c,
  input  logic                 coef_we,
  input  logic [1:0]           coef_row,
  input  logic signed [CW-1:0] coef_k0,
  input  logic signed [CW-1:0] coef_k1,
  input  logic signed [CW-1:0] coef_k2,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y,
  output logic signed [DW-1:0] out_z
);
  localparam int PW   = DW + CW;
  localparam int AW   = PW + 2;
  localparam int RW   = 3 * CW;
  localparam int HALF = 1 << (FRAC - 1);
  localparam logic signed [AW-1:0] MAXA = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINA = AW'(-(1 << (DW - 1)));

  function automatic logic [3*RW-1:0] unit_matrix();
    logic [3*RW-1:0] m;
    m = '0;
    for (int k = 0; k < 3; k++) m[(4*k)*CW +: CW] = CW'(1 << FRAC);
    return m;
  endfunction

  localparam logic [3*RW-1:0] IDENT = unit_matrix();

  function automatic logic signed [DW-1:0] round_clip(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] t;
    t = (a + AW'(HALF)) >>> FRAC;
    if (t > MAXA) return MAXA[DW-1:0];
    if (t < MINA) return MINA[DW-1:0];
    return t[DW-1:0];
  endfunction

  logic                 wr_q;
  logic [1:0]           row_q;
  logic [RW-1:0]        dat_q;
  logic [3*RW-1:0]      shd_q, act_q;
  logic [4:0]           vld_q;
  logic signed [DW-1:0] din_q  [3];
  logic signed [CW-1:0] cf     [9];
  logic signed [PW-1:0] prod_q [9];
  logic signed [AW-1:0] psum_q [3];
  logic signed [AW-1:0] pthr_q [3];
  logic signed [AW-1:0] acc_q  [3];
  logic signed [DW-1:0] dout_q [3];

  always_comb
    for (int k = 0; k < 9; k++) cf[k] = $signed(act_q[k*CW +: CW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      row_q <= '0;
      dat_q <= '0;
      shd_q <= IDENT;
      act_q <= IDENT;
    end else begin
      wr_q  <= coef_we;
      row_q <= coef_row;
      dat_q <= {coef_k2, coef_k1, coef_k0};
      if (wr_q && row_q != 2'd3) shd_q[row_q*RW +: RW] <= dat_q;
      if (wr_q && row_q == 2'd2) act_q <= {dat_q, shd_q[2*RW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < 3; i++) begin
        din_q[i]  <= '0;
        psum_q[i] <= '0;
        pthr_q[i] <= '0;
        acc_q[i]  <= '0;
        dout_q[i] <= '0;
      end
      for (int k = 0; k < 9; k++) prod_q[k] <= '0;
    end else begin
      vld_q    <= {vld_q[3:0], in_valid};
      din_q[0] <= in_a;
      din_q[1] <= in_b;
      din_q[2] <= in_c;
      for (int r = 0; r < 3; r++) begin
        for (int c = 0; c < 3; c++)
          prod_q[r*3+c] <= PW'(din_q[c]) * PW'(cf[r*3+c]);
        psum_q[r] <= AW'(prod_q[r*3]) + AW'(prod_q[r*3+1]);
        pthr_q[r] <= AW'(prod_q[r*3+2]);
        acc_q[r]  <= psum_q[r] + pthr_q[r];
        dout_q[r] <= round_clip(acc_q[r]);
      end
    end
  end

  assign out_valid = vld_q[4];
  assign out_x     = dout_q[0];
  assign out_y     = dout_q[1];
  assign out_z     = dout_q[2];
endmodule

// File: rtl/cmm_checker.sv
module cmm_checker #(
  parameter int DW   = 12,
  parameter int CW   = 10,
  parameter int FRAC = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic                    wr_q,
  input logic [1:0]              row_q,
  input logic [3*CW-1:0]         dat_q,
  input logic [9*CW-1:0]         act_q,
  input logic signed [DW+CW+1:0] acc0,
  input logic signed [DW-1:0]    out_x
);
  localparam int HI = ((1 << (DW - 1)) << FRAC) - (1 << (FRAC - 1));
  localparam int LO = -((1 << (DW - 1)) << FRAC) - (1 << (FRAC - 1));
  localparam logic signed [DW-1:0] OMAX = DW'((1 << (DW - 1)) - 1);
  localparam logic signed [DW-1:0] OMIN = DW'(-(1 << (DW - 1)));

  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd6) |-> (out_valid == $past(in_valid, 5)));

  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && row_q == 2'd2) |=> $stable(act_q));

  assert_commit_row2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && row_q == 2'd2) |=> (act_q[9*CW-1:6*CW] == $past(dat_q)));

  assert_clip_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc0 >= HI) |=> (out_x == OMAX));

  assert_clip_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc0 <= LO) |=> (out_x == OMIN));
endmodule

bind color_matrix_mul cmm_checker #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_cmm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .wr_q      (wr_q),
  .row_q     (row_q),
  .dat_q     (dat_q),
  .act_q     (act_q),
  .acc0      (acc_q[0]),
  .out_x     (out_x)
);

// File: tb/test_color_matrix_mul.sv
module test_color_matrix_mul;
  localparam int DW = 12, CW = 10, FRAC = 8;
  localparam int NV = 8;
  localparam int STIM [NV][3] = '{
    '{0, 0, 0}, '{100, -50, 25}, '{2047, 0, -2048}, '{-2048, 2047, 1},
    '{512, 512, 512}, '{-1, -1, -1}, '{1234, -777, 300}, '{-999, 42, 2000}};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0, coef_we = 1'b0;
  logic signed [DW-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [1:0] coef_row = '0;
  logic signed [CW-1:0] coef_k0 = '0, coef_k1 = '0, coef_k2 = '0;
  logic out_valid;
  logic signed [DW-1:0] out_x, out_y, out_z;

  color_matrix_mul #(.DW(DW), .CW(CW), .FRAC(FRAC)) i_color_matrix_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .coef_we(coef_we), .coef_row(coef_row), .coef_k0(coef_k0), .coef_k1(coef_k1),
    .coef_k2(coef_k2), .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z));

  int errors = 0, checks = 0;
  int ma [9] = '{256, 0, 0, 0, 256, 0, 0, 0, 256};
  int ms [9] = '{256, 0, 0, 0, 256, 0, 0, 0, 256};
  bit ev [5] = '{0, 0, 0, 0, 0};
  int ex [5][3];
  string et [5] = '{"", "", "", "", ""};

  function automatic int predict(int r, int a, int b, int c);
    int acc, t;
    acc = ma[r*3] * a + ma[r*3+1] * b + ma[r*3+2] * c;
    t = (acc + (1 << (FRAC - 1))) >>> FRAC;
    if (t > 2047) t = 2047;
    if (t < -2048) t = -2048;
    return t;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit v, int a, int b, int c,
                     bit we = 0, int row = 0, int k0 = 0, int k1 = 0, int k2 = 0);
    in_valid = v; in_a = DW'(a); in_b = DW'(b); in_c = DW'(c);
    coef_we = we; coef_row = 2'(row);
    coef_k0 = CW'(k0); coef_k1 = CW'(k1); coef_k2 = CW'(k2);
    for (int i = 4; i > 0; i--) begin
      ev[i] = ev[i-1]; et[i] = et[i-1];
      for (int r = 0; r < 3; r++) ex[i][r] = ex[i-1][r];
    end
    ev[0] = v; et[0] = tag;
    for (int r = 0; r < 3; r++) ex[0][r] = predict(r, a, b, c);
    if (we && row < 3) begin
      ms[row*3] = k0; ms[row*3+1] = k1; ms[row*3+2] = k2;
      if (row == 2) ma = ms;
    end
    @(posedge clk); @(negedge clk);
    chk("R6", "out_valid", int'(out_valid), int'(ev[4]));
    if (ev[4]) begin
      chk(et[4], "out_x", int'(out_x), ex[4][0]);
      chk(et[4], "out_y", int'(out_y), ex[4][1]);
      chk(et[4], "out_z", int'(out_z), ex[4][2]);
    end
  endtask

  function automatic int rnd_d();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  task automatic load(string tag, bit stream, int m [9]);
    for (int r = 0; r < 3; r++)
      cyc(tag, stream, rnd_d(), rnd_d(), rnd_d(), 1, r, m[r*3], m[r*3+1], m[r*3+2]);
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) cyc("R6", 0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mat_a [9] = '{256, 0, 292, 256, -101, -149, 256, 511, 0};
    int sat_m [9] = '{511, 511, 511, 511, 511, 511, -512, -512, -512};
    int rnd_m [9] = '{1, 0, 0, -1, 0, 0, 0, 0, 3};
    int rmat  [9];
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "out_x in reset", int'(out_x), 0);
    chk("R1", "out_z in reset", int'(out_z), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "out_y after reset", int'(out_y), 0);

    for (int i = 0; i < NV; i++) cyc("R2", 1, STIM[i][0], STIM[i][1], STIM[i][2]);

    load("R8", 1, mat_a);
    for (int i = 0; i < NV; i++) cyc("R3", 1, STIM[i][0], STIM[i][1], STIM[i][2]);

    cyc("R7", 1, 300, -200, 100, 1, 0, 10, 20, 30);
    cyc("R7", 1, -300, 200, 700, 1, 1, -40, 50, -60);
    for (int i = 0; i < 4; i++) cyc("R7", 1, rnd_d(), rnd_d(), rnd_d());
    cyc("R9", 1, 555, 666, -777, 1, 3, 99, -99, 77);
    for (int i = 0; i < 3; i++) cyc("R9", 1, rnd_d(), rnd_d(), rnd_d());
    cyc("R8", 1, 1000, 1000, 1000, 1, 2, 70, 80, 90);
    for (int i = 0; i < 4; i++) cyc("R9", 1, rnd_d(), rnd_d(), rnd_d());

    load("R5", 0, sat_m);
    cyc("R5", 1, 2047, 2047, 2047);
    cyc("R5", 1, -2048, -2048, -2048);
    cyc("R5", 1, 1, 2, 3);
    cyc("R5", 1, 2047, -2048, 0);

    load("R4", 1, rnd_m);
    cyc("R4", 1, 128, 0, 43);
    cyc("R4", 1, 127, 0, -43);
    cyc("R4", 1, -128, 0, 42);
    cyc("R4", 1, -129, 0, -42);
    cyc("R4", 1, 384, 0, 85);

    for (int i = 0; i < 20; i++) cyc("R6", (i % 3) != 1, rnd_d(), rnd_d(), rnd_d());

    for (int k = 0; k < 9; k++) rmat[k] = int'($urandom_range(0, 1023)) - 512;
    load("R8", 1, rmat);
    for (int i = 0; i < 200; i++) cyc("R3", 1, rnd_d(), rnd_d(), rnd_d());

    flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule